// File: doc/BRIEF.md
# LAN Controller Register-Access Sequencer

This block sits between a host bus and a 16-bit LAN controller chip. The chip exposes two host-visible registers: an address port that selects an internal register, and a data port that reads or writes the register selected. The host never reads the chip directly. It issues accesses in a small word-offset window. A write at one offset starts a controller write cycle. A write at another offset starts a "fetch" that copies a controller port into a 16-bit holding register, and a later host read returns the holding register. The sequencer decodes each offset, drives the chip's select, direction, strobe and port-select lines, and paces each cycle on the chip's ready line.

The sequencer also services the chip's interrupt on its own. A rising interrupt, after a two-flop synchronizer, raises a host interrupt line. It then fetches the data port (the status word) into the holding register, waits for ready to drop, and writes a constant clear word back to the data port. The host interrupt line stays up until the host acknowledges it. A separate block stores the status word to memory, using the ring base address that this block latches.

The host holds `host_sel` for each access and releases it once `host_wait` is low. For a holding-register read, it releases `host_sel` after it has sampled `host_rdata`. `host_ofs[3:0]` carries byte-address bits [4:1]; `host_ofs[0]` is address bit 1.

Top module: `lanc_reg_seq`

## Requirements
- R1: A host write with `host_ofs` 1000 or 1001 latches `host_wdata` and runs one controller write cycle. During the cycle `lc_cs_n`=0, `lc_strb_n`=0, `lc_read`=0, `lc_dal_oe`=1 and `lc_dal_out` = the latched data. `lc_port_sel` equals `host_ofs[0]` (0 = address port, 1 = data port). The strobe is held until `lc_ready` is seen high and released on the next clock.
- R2: A host write with `host_ofs` 1010 or 1011 runs a controller read cycle (`lc_read`=1) on port `host_ofs[0]`, ignoring `host_wdata`. The holding register captures `lc_dal_in` on the clock where `lc_ready` is high, and the machine then returns to idle.
- R3: A host read with `host_ofs` 1100 drives the holding register on `host_rdata` with `host_rd_oe`=1. The value stays stable and no controller cycle starts while `host_sel` stays high. `host_rd_oe` drops one clock after `host_sel` is released.
- R4: A host write with `host_ofs` 0111 loads `ring_base` from `host_wdata` and starts no controller cycle.
- R5: A host write with `host_ofs` 0000 clears the holding register and `host_irq`, ignoring `host_wdata`.
- R6: A rising edge on `lc_irq`, after a two-flop synchronizer, sets `host_irq` and starts a controller read of the data port into the holding register.
- R7: After the interrupt fetch sees ready, the machine waits for `lc_ready` low, then writes `CLR_WORD` (default 16'h7F00) to the data port. It waits for ready, then for ready low, and only then returns to idle.
- R8: `host_irq` stays high until `host_irq_ack` is sampled high, and drops on that clock edge. Further controller interrupts may arrive before the acknowledge.
- R9: When an interrupt is pending and a host access is waiting in idle, the interrupt sequence runs first. `host_wait` is high only while `host_sel` is high and the access is not yet complete.
- R10: A host write at an unassigned offset (for example 0101), or a host read at any offset other than 1100, completes with no controller cycle. It leaves the holding register and `ring_base` unchanged.
- R11: `lc_strb_n` is never low while `lc_cs_n` is high, and `lc_dal_oe` is high only during a controller write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access select, held for the whole access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 4 | Word offset, address bits [4:1] |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Holding register during a holding read, else zero |
| host_rd_oe | output | 1 | Host read data valid/drive enable |
| host_wait | output | 1 | Access not yet complete |
| host_irq | output | 1 | Interrupt to the host |
| host_irq_ack | input | 1 | Host interrupt acknowledge |
| ring_base | output | RING_W | Status ring base for the memory-write block |
| lc_cs_n | output | 1 | Controller chip select, active low |
| lc_strb_n | output | 1 | Controller data strobe, active low |
| lc_read | output | 1 | 1 = controller drives data, 0 = controller receives |
| lc_port_sel | output | 1 | 0 = address port, 1 = data port |
| lc_dal_out | output | DATA_W | Data to the controller |
| lc_dal_oe | output | 1 | Drive enable for `lc_dal_out` |
| lc_dal_in | input | DATA_W | Data from the controller |
| lc_ready | input | 1 | Controller ready |
| lc_irq | input | 1 | Controller interrupt, asynchronous, active high |

## Verification
Port writes and fetches are driven with random data, random port choice and random ready delays. A controller model checks the data against its own register copies, which tells a swapped port select, a stale input latch or a capture on the wrong clock apart from correct behaviour. Directed sequences cover the following cases:
- an interrupt racing a queued host write, which shows whether the priority is right;
- the clear-word write and its ready handshakes;
- acknowledge timing;
- the reset offset;
- unassigned offsets, whose effect is observed through the holding-register read and `ring_base`.

// File: rtl/lanc_pkg.sv
// Shared types for the LAN controller register-access sequencer.
// Assumes: one sequencer state machine and one host decoder share these.
package lanc_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for host access or interrupt
        ST_HREAD,    // host reads holding register
        ST_FETCH,    // controller read into holding register
        ST_WRITE,    // controller write from input latch
        ST_CLRWAIT,  // interrupt: wait for ready to drop
        ST_CLRWR,    // interrupt: write clear word
        ST_CLRDONE   // interrupt: wait for final ready drop
    } seq_state_e;

    // Decoded host operations
    typedef enum logic [2:0] {
        OP_NONE,
        OP_RESET,
        OP_RING,
        OP_WRITE,
        OP_FETCH,
        OP_HREAD
    } host_op_e;

endpackage

// File: rtl/lanc_host_dec.sv
// Host offset decoder.
// Maps direction and word offset to one operation. Purely combinational.
// Assumes: OFS_W is at least 4; codes occupy the low four bits.
module lanc_host_dec
    import lanc_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic             host_wr,
    input  logic [OFS_W-1:0] host_ofs,
    output host_op_e         op
);

    localparam logic [OFS_W-1:0] OFS_RESET = OFS_W'(4'b0000);
    localparam logic [OFS_W-1:0] OFS_RING  = OFS_W'(4'b0111);
    localparam logic [OFS_W-1:0] OFS_WRAP  = OFS_W'(4'b1000);
    localparam logic [OFS_W-1:0] OFS_WRDP  = OFS_W'(4'b1001);
    localparam logic [OFS_W-1:0] OFS_FRAP  = OFS_W'(4'b1010);
    localparam logic [OFS_W-1:0] OFS_FRDP  = OFS_W'(4'b1011);
    localparam logic [OFS_W-1:0] OFS_HOLD  = OFS_W'(4'b1100);

    // Decode one operation from direction and offset
    always_comb begin
        op = OP_NONE;
        if (host_wr) begin
            if (host_ofs == OFS_RESET)                             op = OP_RESET;
            else if (host_ofs == OFS_RING)                         op = OP_RING;
            else if (host_ofs == OFS_WRAP || host_ofs == OFS_WRDP) op = OP_WRITE;
            else if (host_ofs == OFS_FRAP || host_ofs == OFS_FRDP) op = OP_FETCH;
        end else if (host_ofs == OFS_HOLD) begin
            op = OP_HREAD;
        end
    end

endmodule

// File: rtl/lanc_irq_sync.sv
// Interrupt synchronizer and rising-edge detector.
// Assumes: async_in is asynchronous to clk and STAGES >= 2.
module lanc_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer chain and keep last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lanc_seq_fsm.sv
// Sequencer state machine.
// Arbitrates host access against interrupt service, paces controller
// cycles on ready, and owns the host interrupt and wait lines.
// Assumes: controller holds ready high until strobe is released.
module lanc_seq_fsm
    import lanc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  host_op_e   op,
    input  logic       port_bit,
    input  logic       irq_rise,
    input  logic       host_irq_ack,
    input  logic       lc_ready,
    output logic       host_wait,
    output logic       host_irq,
    output logic       host_rd_oe,
    output logic       lc_cs_n,
    output logic       lc_strb_n,
    output logic       lc_read,
    output logic       lc_port_sel,
    output logic       dal_drive,
    output logic       dal_clr_sel,
    output logic       ld_in,
    output logic       ld_hold,
    output logic       ld_ring,
    output logic       clr_hold
);

    seq_state_e state_q, state_d;
    logic       served_q;
    logic       irq_pend_q;
    logic       int_mode_q;
    logic       port_q;
    logic       start_ok, take_irq, take_host;

    assign start_ok  = (state_q == ST_IDLE) && !lc_ready;
    assign take_irq  = start_ok && irq_pend_q;
    assign take_host = start_ok && !irq_pend_q && host_sel && !served_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_irq) begin
                    state_d = ST_FETCH;
                end else if (take_host) begin
                    if (op == OP_WRITE)      state_d = ST_WRITE;
                    else if (op == OP_FETCH) state_d = ST_FETCH;
                    else if (op == OP_HREAD) state_d = ST_HREAD;
                end
            end
            ST_WRITE:   if (lc_ready)  state_d = ST_IDLE;
            ST_FETCH:   if (lc_ready)  state_d = int_mode_q ? ST_CLRWAIT : ST_IDLE;
            ST_CLRWAIT: if (!lc_ready) state_d = ST_CLRWR;
            ST_CLRWR:   if (lc_ready)  state_d = ST_CLRDONE;
            ST_CLRDONE: if (!lc_ready) state_d = ST_IDLE;
            ST_HREAD:   if (!host_sel) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pending interrupt: set on synchronized rise, consumed on service start
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pend_q <= 1'b0;
        else        irq_pend_q <= irq_rise | (irq_pend_q & ~take_irq);
    end

    // Interrupt-sequence flag and latched port select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_mode_q <= 1'b0;
            port_q     <= 1'b0;
        end else begin
            if (take_irq) begin
                int_mode_q <= 1'b1;
                port_q     <= 1'b1;
            end else if (take_host) begin
                port_q     <= port_bit;
            end
            if (state_q == ST_CLRDONE && !lc_ready) int_mode_q <= 1'b0;
        end
    end

    // One service per host select assertion
    always_ff @(posedge clk) begin
        if (!rst_n)        served_q <= 1'b0;
        else if (!host_sel) served_q <= 1'b0;
        else if (take_host) served_q <= 1'b1;
    end

    // Host interrupt line: set on service start, cleared by ack or reset op
    always_ff @(posedge clk) begin
        if (!rst_n)            host_irq <= 1'b0;
        else if (clr_hold)     host_irq <= 1'b0;
        else if (take_irq)     host_irq <= 1'b1;
        else if (host_irq_ack) host_irq <= 1'b0;
    end

    // Controller pin and datapath strobes decoded from state
    always_comb begin
        lc_cs_n     = !(state_q == ST_FETCH || state_q == ST_WRITE || state_q == ST_CLRWR);
        lc_strb_n   = lc_cs_n;
        lc_read     = !(state_q == ST_WRITE || state_q == ST_CLRWR);
        dal_drive   = (state_q == ST_WRITE || state_q == ST_CLRWR);
        dal_clr_sel = (state_q == ST_CLRWR);
        lc_port_sel = port_q;
        host_rd_oe  = (state_q == ST_HREAD);
        ld_hold     = (state_q == ST_FETCH) && lc_ready;
        ld_in       = take_host && (op == OP_WRITE);
        ld_ring     = take_host && (op == OP_RING);
        clr_hold    = take_host && (op == OP_RESET);
        host_wait   = host_sel && !(served_q && (state_q == ST_IDLE || state_q == ST_HREAD));
    end

endmodule

// File: rtl/lanc_data_path.sv
// Data registers: input latch, holding register and ring base.
// Assumes: load strobes are mutually exclusive per cycle; RING_W <= DATA_W.
module lanc_data_path #(
    parameter int              DATA_W   = 16,
    parameter int              RING_W   = 16,
    parameter logic [DATA_W-1:0] CLR_WORD = 16'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] lc_dal_in,
    input  logic              ld_in,
    input  logic              ld_hold,
    input  logic              ld_ring,
    input  logic              clr_hold,
    input  logic              dal_clr_sel,
    input  logic              host_rd_oe,
    output logic [DATA_W-1:0] lc_dal_out,
    output logic [DATA_W-1:0] host_rdata,
    output logic [RING_W-1:0] ring_base
);

    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] hold_q;
    logic [RING_W-1:0] ring_q;

    // Input latch for controller writes
    always_ff @(posedge clk) begin
        if (!rst_n)     in_q <= '0;
        else if (ld_in) in_q <= host_wdata;
    end

    // Holding register for controller fetches
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (clr_hold)  hold_q <= '0;
        else if (ld_hold)   hold_q <= lc_dal_in;
    end

    // Status ring base for the memory-write block
    always_ff @(posedge clk) begin
        if (!rst_n)       ring_q <= '0;
        else if (ld_ring) ring_q <= host_wdata[RING_W-1:0];
    end

    assign lc_dal_out = dal_clr_sel ? CLR_WORD : in_q;
    assign host_rdata = host_rd_oe ? hold_q : '0;
    assign ring_base  = ring_q;

endmodule

// File: rtl/lanc_reg_seq.sv
// LAN controller register-access sequencer, top level.
// Connects the host decoder, interrupt synchronizer, sequencer and data
// registers. Assumes lc_irq is asynchronous; all else is synchronous to clk.
module lanc_reg_seq
    import lanc_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                RING_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] CLR_WORD    = 16'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [3:0]        host_ofs,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rd_oe,
    output logic              host_wait,
    output logic              host_irq,
    input  logic              host_irq_ack,
    output logic [RING_W-1:0] ring_base,
    output logic              lc_cs_n,
    output logic              lc_strb_n,
    output logic              lc_read,
    output logic              lc_port_sel,
    output logic [DATA_W-1:0] lc_dal_out,
    output logic              lc_dal_oe,
    input  logic [DATA_W-1:0] lc_dal_in,
    input  logic              lc_ready,
    input  logic              lc_irq
);

    host_op_e op;
    logic     irq_rise;
    logic     dal_clr_sel, ld_in, ld_hold, ld_ring, clr_hold;

    lanc_host_dec #(.OFS_W(4)) u_dec (
        .host_wr  (host_wr),
        .host_ofs (host_ofs),
        .op       (op)
    );

    lanc_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lc_irq),
        .rise     (irq_rise)
    );

    lanc_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_sel     (host_sel),
        .op           (op),
        .port_bit     (host_ofs[0]),
        .irq_rise     (irq_rise),
        .host_irq_ack (host_irq_ack),
        .lc_ready     (lc_ready),
        .host_wait    (host_wait),
        .host_irq     (host_irq),
        .host_rd_oe   (host_rd_oe),
        .lc_cs_n      (lc_cs_n),
        .lc_strb_n    (lc_strb_n),
        .lc_read      (lc_read),
        .lc_port_sel  (lc_port_sel),
        .dal_drive    (lc_dal_oe),
        .dal_clr_sel  (dal_clr_sel),
        .ld_in        (ld_in),
        .ld_hold      (ld_hold),
        .ld_ring      (ld_ring),
        .clr_hold     (clr_hold)
    );

    lanc_data_path #(
        .DATA_W   (DATA_W),
        .RING_W   (RING_W),
        .CLR_WORD (CLR_WORD)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wdata  (host_wdata),
        .lc_dal_in   (lc_dal_in),
        .ld_in       (ld_in),
        .ld_hold     (ld_hold),
        .ld_ring     (ld_ring),
        .clr_hold    (clr_hold),
        .dal_clr_sel (dal_clr_sel),
        .host_rd_oe  (host_rd_oe),
        .lc_dal_out  (lc_dal_out),
        .host_rdata  (host_rdata),
        .ring_base   (ring_base)
    );

endmodule

// File: rtl/lanc_reg_seq_chk.sv
// Protocol checker for lanc_reg_seq, attached by bind.
// Assumes: observes top-level ports only.
module lanc_reg_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_wr,
    input logic [3:0]        host_ofs,
    input logic              host_wait,
    input logic              host_irq,
    input logic              host_irq_ack,
    input logic              host_rd_oe,
    input logic [DATA_W-1:0] host_rdata,
    input logic              lc_cs_n,
    input logic              lc_strb_n,
    input logic              lc_read,
    input logic              lc_dal_oe
);

    // R11
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lc_strb_n |-> !lc_cs_n);

    // R1
    dal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lc_dal_oe |-> (!lc_read && !lc_strb_n));

    // R9
    wait_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait |-> host_sel);

    // R3
    rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_oe && $past(host_rd_oe)) |-> $stable(host_rdata));

    // R3
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_oe |-> lc_strb_n);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !host_irq_ack && !(host_sel && host_wr && host_ofs == 4'b0000))
        |=> host_irq);

endmodule

bind lanc_reg_seq lanc_reg_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_ofs     (host_ofs),
    .host_wait    (host_wait),
    .host_irq     (host_irq),
    .host_irq_ack (host_irq_ack),
    .host_rd_oe   (host_rd_oe),
    .host_rdata   (host_rdata),
    .lc_cs_n      (lc_cs_n),
    .lc_strb_n    (lc_strb_n),
    .lc_read      (lc_read),
    .lc_dal_oe    (lc_dal_oe)
);

// File: tb/lanc_reg_seq_test.sv
`timescale 1ns/1ps
module lanc_reg_seq_test;

    localparam logic [15:0] CLR = 16'h7F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_irq_ack = 1'b0;
    logic [3:0]  host_ofs = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata, lc_dal_out, ring_base;
    logic        host_rd_oe, host_wait, host_irq;
    logic        lc_cs_n, lc_strb_n, lc_read, lc_port_sel, lc_dal_oe;
    logic [15:0] lc_dal_in = '0;
    logic        lc_ready = 1'b0, lc_irq = 1'b0;

    int n_cmp = 0, n_bad = 0;
    int rdy_delay = 1;
    int irq_raise = 0;
    // controller model state and event log
    logic [15:0] rap_m = '0, rdp_m = '0;
    logic [15:0] ev_data [0:63];
    logic        ev_port [0:63];
    logic        ev_wr   [0:63];
    int          ev_n = 0, early_rel = 0, bad_oe = 0;

    lanc_reg_seq uut (.*);

    always #5 clk = ~clk;

    // Controller model: answers strobes after rdy_delay cycles
    initial begin
        int cnt; bit busy; int irq_seen;
        cnt = 0; busy = 0; irq_seen = 0;
        forever begin
            @(negedge clk);
            if (irq_seen != irq_raise) begin lc_irq = 1'b1; irq_seen = irq_raise; end
            if (!rst_n) begin
                lc_ready = 1'b0; busy = 0;
            end else if (lc_ready) begin
                if (lc_strb_n) lc_ready = 1'b0;
            end else if (!lc_strb_n && !lc_cs_n) begin
                if (!busy) begin
                    busy = 1; cnt = rdy_delay;
                    if (lc_read) lc_dal_in = lc_port_sel ? rdp_m : rap_m;
                end
                if (cnt == 0) begin
                    lc_ready = 1'b1; busy = 0;
                    ev_wr[ev_n % 64]   = !lc_read;
                    ev_port[ev_n % 64] = lc_port_sel;
                    ev_data[ev_n % 64] = lc_read ? lc_dal_in : lc_dal_out;
                    ev_n++;
                    if (!lc_read) begin
                        if (!lc_dal_oe) bad_oe++;
                        if (lc_port_sel) rdp_m = lc_dal_out; else rap_m = lc_dal_out;
                        if (lc_port_sel && lc_dal_out == CLR) lc_irq = 1'b0;
                    end
                end else cnt--;
            end else if (busy) begin
                early_rel++; busy = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_fetch(input logic port);
        return port ? rdp_m : rap_m;
    endfunction

    task automatic host_write(input logic [3:0] ofs, input logic [15:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_ofs = ofs; host_wdata = d;
        do @(negedge clk); while (host_wait);
        host_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_read(input logic [3:0] ofs, output logic [15:0] d, output logic oe);
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = ofs;
        do @(negedge clk); while (host_wait);
        d = host_rdata; oe = host_rd_oe;
        host_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (12) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d, exp_h, rb, saved;
        logic        oe;
        int          e0, seed;
        seed = $urandom(32'h5EED_1234);
        exp_h = '0; rb = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("reset host_irq", 32'(host_irq), 0);
        chk("reset cs", 32'(lc_cs_n), 1);
        chk("reset strobe", 32'(lc_strb_n), 1);
        chk("reset rd_oe", 32'(host_rd_oe), 0);
        chk("reset ring", 32'(ring_base), 0);

        // R1 directed: address port then data port writes
        host_write(4'b1000, 16'h0000);
        chk("R1 port addr", 32'(ev_port[(ev_n-1)%64]), 0);
        chk("R1 write flag", 32'(ev_wr[(ev_n-1)%64]), 1);
        host_write(4'b1001, 16'hA5C3);
        chk("R1 port data", 32'(ev_port[(ev_n-1)%64]), 1);
        chk("R1 write data", 32'(ev_data[(ev_n-1)%64]), 32'h0000A5C3);

        // R2 + R3 directed fetch and read
        rdy_delay = 3;
        host_write(4'b1011, 16'hFFFF);
        exp_h = exp_fetch(1'b1);
        chk("R2 fetch is read", 32'(ev_wr[(ev_n-1)%64]), 0);
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = 4'b1100;
        do @(negedge clk); while (!host_rd_oe);
        saved = host_rdata;
        repeat (3) @(negedge clk);
        chk("R3 hold data", 32'(saved), 32'(exp_h));
        chk("R3 held stable", 32'(host_rdata), 32'(saved));
        chk("R3 oe while sel", 32'(host_rd_oe), 1);
        host_sel = 1'b0;
        @(negedge clk);
        chk("R3 oe drops", 32'(host_rd_oe), 0);

        // R4 ring base
        host_write(4'b0111, 16'h3C21);
        chk("R4 ring base", 32'(ring_base), 32'h3C21);

        // R10 ignored offsets
        e0 = ev_n;
        host_write(4'b0101, 16'h1111);
        host_read(4'b1000, d, oe);
        chk("R10 no cycle", 32'(ev_n), 32'(e0));
        chk("R10 no rd_oe", 32'(oe), 0);
        chk("R10 ring kept", 32'(ring_base), 32'h3C21);
        host_read(4'b1100, d, oe);
        chk("R10 hold kept", 32'(d), 32'(exp_h));

        // Random mix
        for (int i = 0; i < 80; i++) begin
            int k;
            k = $urandom_range(0, 4);
            rdy_delay = $urandom_range(0, 3);
            d = 16'($urandom);
            if (d == CLR) d = ~d;
            case (k)
                0, 1: begin
                    host_write({3'b100, k[0]}, d);
                    chk("R1 rand data", 32'(ev_data[(ev_n-1)%64]), 32'(d));
                    chk("R1 rand port", 32'(ev_port[(ev_n-1)%64]), 32'(k[0]));
                end
                2, 3: begin
                    host_write({3'b101, k[0]}, d);
                    exp_h = exp_fetch(k[0]);
                    host_read(4'b1100, d, oe);
                    chk("R2 rand fetch", 32'(d), 32'(exp_h));
                end
                default: begin
                    host_write(4'b0111, d);
                    chk("R4 rand ring", 32'(ring_base), 32'(d));
                end
            endcase
        end
        chk("R1 strobe held to ready", 32'(early_rel), 0);
        chk("R1 data drive", 32'(bad_oe), 0);

        // R6/R7 interrupt service
        rdy_delay = 2;
        host_write(4'b1001, 16'h0042);
        exp_h = 16'h0042;
        e0 = ev_n;
        irq_raise++;
        repeat (10) @(negedge clk);
        chk("R6 host_irq set", 32'(host_irq), 1);
        wait_idle();
        chk("R6 fetch read", 32'(ev_wr[e0%64]), 0);
        chk("R6 fetch port", 32'(ev_port[e0%64]), 1);
        chk("R7 clear write", 32'(ev_wr[(e0+1)%64]), 1);
        chk("R7 clear data", 32'(ev_data[(e0+1)%64]), 32'(CLR));
        chk("R7 clear port", 32'(ev_port[(e0+1)%64]), 1);
        chk("R7 irq line cleared", 32'(lc_irq), 0);
        host_read(4'b1100, d, oe);
        chk("R6 status held", 32'(d), 32'(exp_h));

        // R8 hold until ack, drop on the ack clock
        repeat (6) @(negedge clk);
        chk("R8 held", 32'(host_irq), 1);
        host_irq_ack = 1'b1;
        @(negedge clk);
        host_irq_ack = 1'b0;
        chk("R8 drop", 32'(host_irq), 0);

        // R9 priority: interrupt pending while host read in progress
        rdp_m = 16'h0BAD;
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = 4'b1100;
        do @(negedge clk); while (!host_rd_oe);
        irq_raise++;
        repeat (6) @(negedge clk);
        host_sel = 1'b0;
        @(negedge clk);
        e0 = ev_n;
        host_sel = 1'b1; host_wr = 1'b1; host_ofs = 4'b1001; host_wdata = 16'h1234;
        @(negedge clk);
        chk("R9 wait during irq", 32'(host_wait), 1);
        do @(negedge clk); while (host_wait);
        host_sel = 1'b0;
        @(negedge clk);
        chk("R9 irq first", 32'(ev_wr[e0%64]), 0);
        chk("R9 clear second", 32'(ev_data[(e0+1)%64]), 32'(CLR));
        chk("R9 host write last", 32'(ev_data[(e0+2)%64]), 32'h1234);
        chk("R9 host_irq", 32'(host_irq), 1);

        // R5 reset offset clears hold and host_irq
        host_write(4'b0000, 16'hFFFF);
        chk("R5 irq cleared", 32'(host_irq), 0);
        host_read(4'b1100, d, oe);
        chk("R5 hold cleared", 32'(d), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule